// File: doc/BRIEF.md
# Little-Endian Byte-Lane Load/Store Unit

This unit sits between a 32-bit register file and a data memory that is 32 bits wide and byte addressed. Memory is little-endian: a word's lowest byte address holds its least significant byte, and a word is addressed by that lowest byte. A load or store request carries a byte address, an access size, store data and a direction. One clock later the unit presents a word-aligned memory command. A store command carries per-lane byte enables and store data that has been steered onto the lanes.

Loads return through the same unit. The memory reports the fetched word with a valid strobe. One clock later the unit delivers the addressed byte, half-word or word, zero-extended to 32 bits. A request whose address does not fit its size, or whose size code is reserved, issues no memory command. Instead it raises a one-cycle error pulse.

Size codes on `req_size`: 0 is byte, 1 is half-word, 2 is word and 3 is reserved. Address bits 1:0 give the byte offset within the memory word.

Top module: `lsu_lane_unit`

## Requirements
- R1: While `rst_n` is low and on the first cycle after release, every output is zero.
- R2: One cycle after an accepted request, `mem_addr` equals `req_addr` with bits 1:0 forced to zero.
- R3: An aligned word store (size 2, offset 0) drives `mem_be` = 4'b1111 and `mem_wdata` equal to the register value, with `mem_we` = 1.
- R4: A half-word store (size 1) at offset 0 drives `mem_be` = 4'b0011, and at offset 2 drives 4'b1100. Register bits 15:0 appear in both bits 15:0 and bits 31:16 of `mem_wdata`.
- R5: A byte store (size 0) drives a one-hot `mem_be` whose set bit equals address bits 1:0. Register bits 7:0 appear in every byte of `mem_wdata`.
- R6: An accepted load drives `mem_req` = 1, `mem_we` = 0 and `mem_be` = 4'b0000.
- R7: A byte load returns the memory byte at lane (address bits 1:0) in `ld_data` bits 7:0 with bits 31:8 zero. `ld_valid` pulses on the cycle after `mem_rvalid`.
- R8: A half-word load returns lanes {1,0} at offset 0, or lanes {3,2} at offset 2, in `ld_data` bits 15:0 with bits 31:16 zero.
- R9: A word load returns the whole memory word unchanged.
- R10: A half-word at an odd offset, or a word at a nonzero offset, raises `misalign_err` for one cycle. It issues no memory command (`mem_req` = 0, `mem_be` = 0).
- R11: Size code 3 is always rejected in the same way as a misaligned access.
- R12: A cycle without `req_valid` is followed by a cycle with `mem_req` = 0 and `misalign_err` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 half-word, 2 word, 3 reserved |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Register value to store |
| mem_req | output | 1 | Memory command valid |
| mem_we | output | 1 | Memory command is a write |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_be | output | 4 | Per-lane write enables |
| mem_wdata | output | 32 | Lane-steered write data |
| mem_rvalid | input | 1 | Memory read word valid |
| mem_rdata | input | 32 | Memory read word |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Zero-extended load result |
| misalign_err | output | 1 | One-cycle rejected-access pulse |

## Verification
The lane decode has a direct view at the ports. A wrong lane selection shows up in `mem_be` or `mem_wdata` on the cycle after the request. A wrong acceptance decision shows up as a missing or spurious `mem_req` or `misalign_err` pulse in that same cycle. A corrupted load context (saved size or offset) appears only when the next read word comes back, as a wrong lane or a nonzero upper field in `ld_data` one cycle after `mem_rvalid`. The random stimulus therefore pairs each load with a random read word, so that every lane carries distinct data.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;
endpackage

// File: rtl/lsu_lane_decode.sv
module lsu_lane_decode
  import lsu_pkg::*;
#(
  parameter int LANES = 4,
  parameter int OFF_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chk_en,
  input  acc_size_e        size,
  input  logic [OFF_W-1:0] off,
  output logic [LANES-1:0] lane_sel,
  output logic             bad
);

  // does a given lane take part in an access of this size at this offset
  function automatic logic lane_hit(input int lane, input acc_size_e sz,
                                    input logic [OFF_W-1:0] o);
    logic [OFF_W-1:0] ln;
    ln = OFF_W'(lane);
    case (sz)
      SZ_BYTE: lane_hit = (o == ln);
      SZ_HALF: lane_hit = ((o >> 1) == (ln >> 1));
      SZ_WORD: lane_hit = 1'b1;
      default: lane_hit = 1'b0;
    endcase
  endfunction

  function automatic logic is_misaligned(input acc_size_e sz,
                                         input logic [OFF_W-1:0] o);
    case (sz)
      SZ_BYTE: is_misaligned = 1'b0;
      SZ_HALF: is_misaligned = o[0];
      SZ_WORD: is_misaligned = (o != '0);
      default: is_misaligned = 1'b1;
    endcase
  endfunction

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_sel[g] = lane_hit(g, size, off);
  end

  assign bad = is_misaligned(size, off);

  AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && size == SZ_BYTE) |-> $onehot(lane_sel)) else $error("byte lanes"); // R5
  AST_HALF_TWO_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && size == SZ_HALF && !bad) |-> ($countones(lane_sel) == 2)) else $error("half lanes"); // R4

endmodule

// File: rtl/lsu_store_steer.sv
module lsu_store_steer
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANES  = DATA_W / 8
) (
  input  acc_size_e         size,
  input  logic [DATA_W-1:0] reg_data,
  output logic [DATA_W-1:0] lane_data
);

  // byte placed on lane g: the register byte that lane would carry for this size
  function automatic logic [7:0] lane_byte(input int lane, input acc_size_e sz,
                                           input logic [DATA_W-1:0] d);
    case (sz)
      SZ_BYTE: lane_byte = d[7:0];
      SZ_HALF: lane_byte = d[(lane % 2) * 8 +: 8];
      default: lane_byte = d[lane * 8 +: 8];
    endcase
  endfunction

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_data[g*8 +: 8] = lane_byte(g, size, reg_data);
  end

endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OFF_W  = 2
) (
  input  acc_size_e         size,
  input  logic [OFF_W-1:0]  off,
  input  logic [DATA_W-1:0] word,
  output logic [DATA_W-1:0] result
);

  function automatic logic [DATA_W-1:0] pick(input acc_size_e sz,
                                             input logic [OFF_W-1:0] o,
                                             input logic [DATA_W-1:0] w);
    int base;
    pick = '0;
    case (sz)
      SZ_BYTE: begin
        base = int'(o) * 8;
        pick[7:0] = w[base +: 8];
      end
      SZ_HALF: begin
        base = ((int'(o) >> 1) << 1) * 8;
        pick[15:0] = w[base +: 16];
      end
      default: pick = w;
    endcase
  endfunction

  assign result = pick(size, off, word);

endmodule

// File: rtl/lsu_lane_unit.sv
module lsu_lane_unit
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic                  req_store,
  input  logic [1:0]            req_size,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [DATA_W-1:0]     req_wdata,
  output logic                  mem_req,
  output logic                  mem_we,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic [DATA_W/8-1:0]   mem_be,
  output logic [DATA_W-1:0]     mem_wdata,
  input  logic                  mem_rvalid,
  input  logic [DATA_W-1:0]     mem_rdata,
  output logic                  ld_valid,
  output logic [DATA_W-1:0]     ld_data,
  output logic                  misalign_err
);

  localparam int LANES = DATA_W / 8;
  localparam int OFF_W = $clog2(LANES);

  acc_size_e         sz_in;
  logic [OFF_W-1:0]  off_in;
  logic [LANES-1:0]  lane_sel;
  logic              bad;
  logic [DATA_W-1:0] st_lanes;
  logic              accept_store;
  logic              accept_load;
  logic              raise_err;

  acc_size_e         ctx_size;
  logic [OFF_W-1:0]  ctx_off;
  logic [DATA_W-1:0] ld_pick;

  assign sz_in  = acc_size_e'(req_size);
  assign off_in = req_addr[OFF_W-1:0];

  lsu_lane_decode #(.LANES(LANES), .OFF_W(OFF_W)) u_decode (
    .clk      (clk),
    .rst_n    (rst_n),
    .chk_en   (req_valid),
    .size     (sz_in),
    .off      (off_in),
    .lane_sel (lane_sel),
    .bad      (bad)
  );

  lsu_store_steer #(.DATA_W(DATA_W), .LANES(LANES)) u_steer (
    .size      (sz_in),
    .reg_data  (req_wdata),
    .lane_data (st_lanes)
  );

  lsu_load_extract #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_extract (
    .size   (ctx_size),
    .off    (ctx_off),
    .word   (mem_rdata),
    .result (ld_pick)
  );

  assign accept_store = req_valid &  req_store & ~bad;
  assign accept_load  = req_valid & ~req_store & ~bad;
  assign raise_err    = req_valid & bad;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_req      <= 1'b0;
      mem_we       <= 1'b0;
      mem_addr     <= '0;
      mem_be       <= '0;
      mem_wdata    <= '0;
      misalign_err <= 1'b0;
      ctx_size     <= SZ_WORD;
      ctx_off      <= '0;
      ld_valid     <= 1'b0;
      ld_data      <= '0;
    end else begin
      mem_req      <= accept_store | accept_load;
      mem_we       <= accept_store;
      mem_addr     <= {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
      mem_be       <= accept_store ? lane_sel : '0;
      mem_wdata    <= accept_store ? st_lanes : '0;
      misalign_err <= raise_err;
      if (accept_load) begin
        ctx_size <= sz_in;
        ctx_off  <= off_in;
      end
      ld_valid <= mem_rvalid;
      if (mem_rvalid) ld_data <= ld_pick;
    end
  end

  AST_ADDR_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (mem_addr[ADDR_W-1:OFF_W] == $past(req_addr[ADDR_W-1:OFF_W])
                   && mem_addr[OFF_W-1:0] == '0)) else $error("addr"); // R2
  AST_STORE_BE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2
                || $countones(mem_be) == LANES)) else $error("be count"); // R5
  AST_LOAD_NO_BE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> (mem_be == '0)) else $error("load be"); // R6
  AST_LD_FOLLOWS_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rvalid |=> ld_valid) else $error("ld valid"); // R7
  AST_ERR_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    misalign_err |-> (!mem_req && mem_be == '0)) else $error("err req"); // R10
  AST_RSVD_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size == 2'd3) |=> misalign_err) else $error("rsvd"); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!mem_req && !misalign_err)) else $error("idle"); // R12

endmodule

// File: tb/test_lsu_lane_unit.sv
`timescale 1ns/1ps
module test_lsu_lane_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_store = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [31:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        mem_req, mem_we, ld_valid, misalign_err;
  logic [31:0] mem_addr, mem_wdata, ld_data;
  logic [3:0]  mem_be;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  lsu_lane_unit i_lsu_lane_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .ld_valid(ld_valid), .ld_data(ld_data), .misalign_err(misalign_err)
  );

  function automatic bit ref_bad(input logic [1:0] sz, input logic [1:0] o);
    if (sz == 2'd3) return 1'b1;
    if (sz == 2'd2) return o != 2'd0;
    if (sz == 2'd1) return o[0];
    return 1'b0;
  endfunction

  function automatic logic [3:0] ref_be(input logic [1:0] sz, input logic [1:0] o);
    if (sz == 2'd0) return 4'b0001 << o;
    if (sz == 2'd1) return 4'b0011 << {o[1], 1'b0};
    return 4'b1111;
  endfunction

  function automatic logic [31:0] ref_wdata(input logic [1:0] sz, input logic [31:0] d);
    if (sz == 2'd0) return {4{d[7:0]}};
    if (sz == 2'd1) return {2{d[15:0]}};
    return d;
  endfunction

  function automatic logic [31:0] ref_load(input logic [1:0] sz, input logic [1:0] o,
                                           input logic [31:0] w);
    logic [31:0] s;
    if (sz == 2'd0) begin
      s = w >> (o * 8);
      return s & 32'h0000_00FF;
    end
    if (sz == 2'd1) begin
      s = w >> ({o[1], 1'b0} * 8);
      return s & 32'h0000_FFFF;
    end
    return w;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one request; results sampled on the negedge after the capturing posedge
  task automatic access(input bit st, input logic [1:0] sz, input logic [31:0] a,
                        input logic [31:0] d, input logic [31:0] rword);
    bit bad;
    bad = ref_bad(sz, a[1:0]);
    @(negedge clk);
    req_valid = 1'b1; req_store = st; req_size = sz; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    if (bad) begin
      chk(sz == 2'd3 ? "R11 err" : "R10 err", {31'd0, misalign_err}, 32'd1);
      chk(sz == 2'd3 ? "R11 no req" : "R10 no req", {27'd0, mem_req, mem_be}, 32'd0);
    end else begin
      chk("R10 no err", {31'd0, misalign_err}, 32'd0);
      chk("R2 addr", mem_addr, {a[31:2], 2'b00});
      if (st) begin
        chk(sz == 2'd2 ? "R3 req/we/be" : (sz == 2'd1 ? "R4 req/we/be" : "R5 req/we/be"),
            {26'd0, mem_req, mem_we, mem_be}, {26'd0, 2'b11, ref_be(sz, a[1:0])});
        chk(sz == 2'd2 ? "R3 wdata" : (sz == 2'd1 ? "R4 wdata" : "R5 wdata"),
            mem_wdata, ref_wdata(sz, d));
      end else begin
        chk("R6 req/we/be", {26'd0, mem_req, mem_we, mem_be}, {26'd0, 2'b10, 4'd0});
        mem_rvalid = 1'b1; mem_rdata = rword;
        @(negedge clk);
        mem_rvalid = 1'b0;
        chk("R7 ld_valid", {31'd0, ld_valid}, 32'd1);
        chk(sz == 2'd0 ? "R7 ld_data" : (sz == 2'd1 ? "R8 ld_data" : "R9 ld_data"),
            ld_data, ref_load(sz, a[1:0], rword));
      end
    end
  endtask

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'h5EED_1234);
    repeat (3) @(negedge clk);
    chk("R1 reset", {mem_req, mem_we, mem_be, misalign_err, ld_valid, 24'd0}, 32'd0);
    chk("R1 reset data", mem_wdata | ld_data | mem_addr, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {28'd0, mem_req, misalign_err, ld_valid, mem_we}, 32'd0);
    @(negedge clk);
    chk("R12 idle", {30'd0, mem_req, misalign_err}, 32'd0);

    // directed corners
    access(1, 2'd2, 32'h0000_1000, 32'hA1B2_C3D4, 0);                 // R3
    access(1, 2'd1, 32'h0000_2000, 32'h1122_3344, 0);                 // R4 low
    access(1, 2'd1, 32'h0000_2002, 32'h5566_7788, 0);                 // R4 high
    for (int k = 0; k < 4; k++)
      access(1, 2'd0, 32'h0000_3000 + k, 32'hDEAD_BE00 + k, 0);       // R5
    for (int k = 0; k < 4; k++)
      access(0, 2'd0, 32'h0000_4000 + k, 0, 32'h8899_AABB);           // R7
    access(0, 2'd1, 32'h0000_5000, 0, 32'hF0E1_D2C3);                 // R8
    access(0, 2'd1, 32'h0000_5002, 0, 32'hF0E1_D2C3);                 // R8
    access(0, 2'd2, 32'h0000_6000, 0, 32'hCAFE_F00D);                 // R9
    access(1, 2'd1, 32'h0000_7001, 32'hFFFF_FFFF, 0);                 // R10
    access(0, 2'd2, 32'h0000_7002, 0, 0);                             // R10
    access(1, 2'd2, 32'h0000_7003, 32'hFFFF_FFFF, 0);                 // R10
    access(1, 2'd3, 32'h0000_8000, 32'h1234_5678, 0);                 // R11
    access(0, 2'd3, 32'h0000_8000, 0, 0);                             // R11
    @(negedge clk);
    chk("R12 quiet after error", {30'd0, mem_req, misalign_err}, 32'd0);

    // constrained random mix
    for (int i = 0; i < 400; i++) begin
      logic [1:0] sz;
      sz = ($urandom % 8 == 0) ? 2'd3 : 2'($urandom % 3);
      access(1'($urandom % 2), sz, $urandom, $urandom, $urandom);
      if ($urandom % 4 == 0) begin
        @(negedge clk);
        chk("R12 random idle", {30'd0, mem_req, misalign_err}, 32'd0);
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule